// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block watches the access stream of an asynchronous SRAM-style bus. The bus pins are brought into the system clock domain through a two-flop synchronizer. No command register exists. A host asks for a transfer between the SRAM array and its shadow nonvolatile array by reading six magic addresses in a fixed order, one per falling edge of chip enable. The last address selects the command. 0x0C63 asks for a RECALL, which copies the nonvolatile array into the SRAM. 0x0FC0 asks for a STORE, which copies the SRAM into the nonvolatile array.

When a sequence completes, the block emits a one-cycle `store_start_o` or `recall_start_o` pulse. It then holds `busy_o` for a parameterized number of cycles. While busy, the block ignores all bus cycles. The magic reads remain ordinary SRAM reads, and their data path lies outside this block. A low-voltage inhibit flag has two effects: it suppresses STORE requests, and it masks the SRAM write strobe that passes through the block.

The controller has seven states:
- `ST_WAIT1`: waiting for the first address.
- `ST_GOT1` to `ST_GOT5`: that many addresses have matched.
- `ST_BUSY`: a transfer is in progress.

Its transitions are:
- **advance**: the expected address arrives on a clean read edge.
- **restart**: a mismatching 0x0E38 arrives, and the controller goes to `ST_GOT1`.
- **abort**: a mismatch, a write edge or a double-clocked edge sends the controller to `ST_WAIT1`.
- **launch**: a valid sixth address arrives, and the controller goes from `ST_GOT5` to `ST_BUSY`.
- **drop**: a STORE address arrives under inhibit, and the controller goes from `ST_GOT5` to `ST_WAIT1`.
- **expire**: the timer reaches zero, and the controller goes from `ST_BUSY` to `ST_WAIT1`.

Top module: `nvcmd_detector`

## Requirements
- R1: After reset, `busy_o`, `store_start_o` and `recall_start_o` are all low, and the detector expects step one.
- R2: Six chip-enable falling edges with write enable high, carrying 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63 in that order, produce exactly one single-cycle `recall_start_o` pulse.
- R3: The same first five addresses followed by 0x0FC0 produce exactly one single-cycle `store_start_o` pulse, provided inhibit is low.
- R4: `busy_o` rises in the same cycle as the start pulse. It stays high for exactly RECALL_CYC cycles after a RECALL, or STORE_CYC cycles after a STORE.
- R5: An address that does not match the expected step sends the detector back to step one. If that address is 0x0E38, it counts as step one. A wrong sixth address produces no pulse.
- R6: A chip-enable falling edge sampled with write enable low aborts the run back to step one.
- R7: A falling edge that arrives MIN_GAP cycles or fewer after the previous falling edge is double clocking. It aborts the run and is not counted as a step.
- R8: While `lv_inhibit_i` is high, a STORE sequence produces no pulse and no busy, and `sram_we_n_o` is held high. A RECALL sequence still completes.
- R9: While `busy_o` is high, chip-enable cycles do not advance any sequence. After busy ends, the detector expects step one.
- R10: The start pulse appears on the third rising clock edge, counting from the edge that first samples the final chip enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Bus address |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| lv_inhibit_i | input | 1 | Low-voltage inhibit flag |
| sram_we_n_o | output | 1 | Write strobe passed to the array, forced high under inhibit |
| store_start_o | output | 1 | One-cycle STORE request |
| recall_start_o | output | 1 | One-cycle RECALL request |
| busy_o | output | 1 | Transfer in progress |

## Verification
The sequence detector is driven with several kinds of address run:
- The two clean command runs, which distinguish STORE from RECALL.
- Runs that begin with a stray address or a doubled 0x0E38, which show that a restart lands on step two rather than step one.
- A run broken mid-way, a run with a wrong final address and a reversed run, none of which may fire.
- Write edges placed inside a run, which show that a write aborts it.

Directed tests follow. One splits a chip-enable low into two close falling edges to trigger the double-clock abort. One counts the busy window cycle by cycle and measures pulse latency. One feeds five steps during busy and then the sixth after busy ends. This last test separates ignoring edges from merely suppressing the pulse.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    typedef enum logic [2:0] {
        ST_WAIT1 = 3'd0,
        ST_GOT1  = 3'd1,
        ST_GOT2  = 3'd2,
        ST_GOT3  = 3'd3,
        ST_GOT4  = 3'd4,
        ST_GOT5  = 3'd5,
        ST_BUSY  = 3'd6
    } seq_state_e;

    localparam logic [15:0] CMD_RECALL = 16'h0C63;
    localparam logic [15:0] CMD_STORE  = 16'h0FC0;

    // Address expected as the next step, given how many steps have matched.
    function automatic logic [15:0] step_addr(input logic [2:0] matched);
        logic [15:0] a;
        unique case (matched)
            3'd0:    a = 16'h0E38;
            3'd1:    a = 16'h31C7;
            3'd2:    a = 16'h03E0;
            3'd3:    a = 16'h3C1F;
            3'd4:    a = 16'h303F;
            default: a = 16'h0000;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nvcmd_edge_sync.sv
module nvcmd_edge_sync #(
    parameter int ADDR_W  = 15,
    parameter int MIN_GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fall_o,
    output logic              dbl_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

    logic              ce_s1, ce_s2, ce_s3;
    logic              we_s1, we_s2;
    logic [ADDR_W-1:0] ad_s1, ad_s2;
    logic [GAP_W-1:0]  gap_q;
    logic              edge_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_s1 <= 1'b1;
            ce_s2 <= 1'b1;
            ce_s3 <= 1'b1;
            we_s1 <= 1'b1;
            we_s2 <= 1'b1;
            ad_s1 <= '0;
            ad_s2 <= '0;
        end else begin
            ce_s1 <= ce_n_i;
            ce_s2 <= ce_s1;
            ce_s3 <= ce_s2;
            we_s1 <= we_n_i;
            we_s2 <= we_s1;
            ad_s1 <= addr_i;
            ad_s2 <= ad_s1;
        end
    end

    assign edge_w = ce_s3 & ~ce_s2;

    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= GAP_MAX;
        else if (edge_w)        gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    assign fall_o = edge_w & (gap_q == GAP_MAX);
    assign dbl_o  = edge_w & (gap_q != GAP_MAX);
    assign we_n_o = we_s2;
    assign addr_o = ad_s2;

    // R7: a counted edge restarts the spacing window, so the next cycle cannot be a clean edge
    p_edge_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/nvcmd_busy_timer.sv
module nvcmd_busy_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R4: the window shrinks by one each cycle it is not reloaded
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nvcmd_seq_fsm.sv
module nvcmd_seq_fsm
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int CNT_W      = 12,
    parameter int STORE_CYC  = 1250,
    parameter int RECALL_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              dbl_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inhibit_i,
    input  logic              tmr_done_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic              store_o,
    output logic              recall_o,
    output logic              busy_o
);

    localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYC - 1);
    localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYC - 1);
    localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(step_addr(3'd0));
    localparam logic [ADDR_W-1:0] A_RECALL = ADDR_W'(CMD_RECALL);
    localparam logic [ADDR_W-1:0] A_STORE  = ADDR_W'(CMD_STORE);

    seq_state_e state_q, state_d;
    logic       go_store, go_recall, abort_w;

    assign abort_w = dbl_i | (fall_i & ~we_n_i);

    always_comb begin
        state_d   = state_q;
        go_store  = 1'b0;
        go_recall = 1'b0;
        unique case (state_q)
            ST_WAIT1, ST_GOT1, ST_GOT2, ST_GOT3, ST_GOT4: begin
                if (abort_w)
                    state_d = ST_WAIT1;
                else if (fall_i) begin
                    if (addr_i == ADDR_W'(step_addr(state_q)))
                        state_d = seq_state_e'(state_q + 3'd1);
                    else if (addr_i == A_FIRST)
                        state_d = ST_GOT1;
                    else
                        state_d = ST_WAIT1;
                end
            end
            ST_GOT5: begin
                if (abort_w)
                    state_d = ST_WAIT1;
                else if (fall_i) begin
                    if (addr_i == A_RECALL) begin
                        state_d   = ST_BUSY;
                        go_recall = 1'b1;
                    end else if (addr_i == A_STORE && !inhibit_i) begin
                        state_d  = ST_BUSY;
                        go_store = 1'b1;
                    end else if (addr_i == A_FIRST)
                        state_d = ST_GOT1;
                    else
                        state_d = ST_WAIT1;
                end
            end
            ST_BUSY: begin
                if (tmr_done_i) state_d = ST_WAIT1;
            end
            default: state_d = ST_WAIT1;
        endcase
    end

    assign tmr_load_o = go_store | go_recall;
    assign tmr_val_o  = go_store ? STORE_LD : RECALL_LD;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT1;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_o  <= 1'b0;
            recall_o <= 1'b0;
        end else begin
            store_o  <= go_store;
            recall_o <= go_recall;
        end
    end

    assign busy_o = (state_q == ST_BUSY);

    // R9: while busy, no bus edge can move the controller anywhere but back to step one
    p_busy_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> (state_q == ST_BUSY || state_q == ST_WAIT1));

    // R2: a start pulse only follows the fifth matched step
    p_launch_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o || recall_o) |-> ($past(state_q) == ST_GOT5));

endmodule

// File: rtl/nvcmd_detector.sv
module nvcmd_detector #(
    parameter int ADDR_W     = 15,
    parameter int MIN_GAP    = 4,
    parameter int STORE_CYC  = 1250,
    parameter int RECALL_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              lv_inhibit_i,
    output logic              sram_we_n_o,
    output logic              store_start_o,
    output logic              recall_start_o,
    output logic              busy_o
);

    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              fall_w, dbl_w, we_s_w, ld_w, done_w;
    logic [ADDR_W-1:0] addr_s_w;
    logic [CNT_W-1:0]  val_w;

    nvcmd_edge_sync #(.ADDR_W(ADDR_W), .MIN_GAP(MIN_GAP)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .we_n_i(we_n_i),
        .addr_i(addr_i), .fall_o(fall_w), .dbl_o(dbl_w),
        .we_n_o(we_s_w), .addr_o(addr_s_w)
    );

    nvcmd_seq_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W),
                    .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .dbl_i(dbl_w),
        .we_n_i(we_s_w), .addr_i(addr_s_w), .inhibit_i(lv_inhibit_i),
        .tmr_done_i(done_w), .tmr_load_o(ld_w), .tmr_val_o(val_w),
        .store_o(store_start_o), .recall_o(recall_start_o), .busy_o(busy_o)
    );

    nvcmd_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(ld_w), .val_i(val_w), .done_o(done_w)
    );

    assign sram_we_n_o = we_n_i | lv_inhibit_i;

    // R2, R3: the two requests never fire together
    p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_start_o && recall_start_o));

    // R4: busy accompanies every start pulse
    p_busy_with_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start_o || recall_start_o) |-> busy_o);

    // R8: no STORE is launched from a cycle where inhibit was high
    p_store_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_start_o |-> !$past(lv_inhibit_i));

    // R2: a recall request lasts one cycle
    p_recall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start_o |=> !recall_start_o);

endmodule

// File: tb/nvcmd_detector_tb.sv
`timescale 1ns/1ps
module nvcmd_detector_tb;

    localparam int ADDR_W     = 15;
    localparam int STORE_CYC  = 1250;
    localparam int RECALL_CYC = 2500;
    localparam int NV         = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic ce_n = 1'b1, we_n = 1'b1, inh = 1'b0;
    logic sram_we_n, st_p, rc_p, busy;

    int checks = 0, errors = 0;
    int n_store = 0, n_recall = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nvcmd_detector #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .we_n_i(we_n),
        .lv_inhibit_i(inh), .sram_we_n_o(sram_we_n), .store_start_o(st_p),
        .recall_start_o(rc_p), .busy_o(busy)
    );

    always @(negedge clk) begin
        if (st_p) n_store++;
        if (rc_p) n_recall++;
    end

    // Seven slots per run; bit i of the mask is we_n for slot i; result 0 none, 1 store, 2 recall.
    localparam logic [15:0] V_ADDR [NV][7] = '{
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63},
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0FC0},
        '{16'h0E38, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63},
        '{16'h0E38, 16'h31C7, 16'h1234, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63},
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0E38},
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63},
        '{16'h0E38, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63},
        '{16'h0000, 16'h0C63, 16'h303F, 16'h3C1F, 16'h03E0, 16'h31C7, 16'h0E38},
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0FC0},
        '{16'h0000, 16'h0E38, 16'h31C7, 16'h03E0, 16'h3C1F, 16'h303F, 16'h0C63}
    };
    localparam logic [6:0] V_WE  [NV] = '{7'h7F, 7'h7F, 7'h7F, 7'h7F, 7'h7F,
                                          7'b1110111, 7'b1111110, 7'h7F, 7'h7F, 7'h7F};
    localparam bit         V_INH [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int         V_EXP [NV] = '{2, 1, 2, 0, 0, 0, 2, 0, 0, 2};
    localparam string      V_REQ [NV] = '{"R2", "R3", "R5", "R5", "R5", "R6", "R6", "R5", "R8", "R8"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input logic [15:0] a, input logic w);
        addr = a[ADDR_W-1:0];
        we_n = w;
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, r0, cnt;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 busy", int'(busy), 0);
        check("R1 store", int'(st_p), 0);
        check("R1 recall", int'(rc_p), 0);

        for (int v = 0; v < NV; v++) begin
            inh = V_INH[v];
            do_reset();
            s0 = n_store; r0 = n_recall;
            for (int k = 0; k < 7; k++) access(V_ADDR[v][k], V_WE[v][k]);
            check({V_REQ[v], " store"},  n_store - s0,  (V_EXP[v] == 1) ? 1 : 0);
            check({V_REQ[v], " recall"}, n_recall - r0, (V_EXP[v] == 2) ? 1 : 0);
            wait_idle();
        end
        inh = 1'b0;

        // R10 and R4: latency and busy window for RECALL
        do_reset();
        access(16'h0E38, 1'b1); access(16'h31C7, 1'b1); access(16'h03E0, 1'b1);
        access(16'h3C1F, 1'b1); access(16'h303F, 1'b1);
        addr = 15'h0C63; ce_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R10 no pulse before third edge", int'(rc_p), 0);
        cnt = 0;
        @(negedge clk);
        check("R10 pulse on third edge", int'(rc_p), 1);
        check("R4 busy with pulse", int'(busy), 1);
        @(negedge clk);
        check("R2 pulse single cycle", int'(rc_p), 0);
        ce_n = 1'b1;
        cnt = 2;
        for (int i = 0; i < 5000 && busy; i++) begin
            @(negedge clk);
            if (busy) cnt++;
        end
        check("R4 recall busy length", cnt, RECALL_CYC);

        // R4: STORE busy window
        do_reset();
        access(16'h0E38, 1'b1); access(16'h31C7, 1'b1); access(16'h03E0, 1'b1);
        access(16'h3C1F, 1'b1); access(16'h303F, 1'b1);
        addr = 15'h0FC0; ce_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (i == 4) ce_n = 1'b1;
            if (busy) cnt++;
            if (i > 4 && !busy) break;
        end
        check("R4 store busy length", cnt, STORE_CYC);

        // R9: five steps fed during busy, sixth after busy must not fire
        do_reset();
        access(16'h0E38, 1'b1); access(16'h31C7, 1'b1); access(16'h03E0, 1'b1);
        access(16'h3C1F, 1'b1); access(16'h303F, 1'b1); access(16'h0C63, 1'b1);
        check("R9 busy entered", int'(busy), 1);
        access(16'h0E38, 1'b1); access(16'h31C7, 1'b1); access(16'h03E0, 1'b1);
        access(16'h3C1F, 1'b1); access(16'h303F, 1'b1);
        wait_idle();
        r0 = n_recall;
        access(16'h0C63, 1'b1);
        check("R9 edges during busy ignored", n_recall - r0, 0);

        // R7: double-clocked fourth step aborts the run
        do_reset();
        r0 = n_recall;
        access(16'h0E38, 1'b1); access(16'h31C7, 1'b1); access(16'h03E0, 1'b1);
        addr = 15'h3C1F; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1;
        repeat (6) @(negedge clk);
        access(16'h303F, 1'b1); access(16'h0C63, 1'b1);
        check("R7 double clock aborts", n_recall - r0, 0);

        // R8: write strobe masking at the array
        we_n = 1'b0; inh = 1'b1;
        #1;
        check("R8 write blocked", int'(sram_we_n), 1);
        inh = 1'b0;
        #1;
        check("R8 write passes", int'(sram_we_n), 0);
        we_n = 1'b1;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule